// File: doc/BRIEF.md
# Serial-Controlled SAR Conversion Sequencer

This block is the digital control core of an eight-input, 12-bit successive-approximation converter. It sits behind a four-wire serial port: an active-low chip select, a serial clock, a data-in line and a data-out line. A strobe output goes beside them. A host clocks in an 8-bit control byte. The block finds the start of that byte without any framing, opens the acquisition window, and runs twelve SAR bit decisions against a single-bit comparator input. It then presents the result MSB first on the data-out line.

Conversions can be paced by the serial clock itself (external mode). They can also be paced by a tick input that stands in for an on-chip oscillator (internal mode). In internal mode the result waits in a register until the host reads it. The analog track/hold, the capacitive DAC and the reference are outside the block. The block drives the trial word towards them and receives back the comparator decision. All serial lines and the tick are synchronised into one system clock. Tri-state pins are modelled as a value plus an enable.

Top module: `sar_serial_seq`

## Requirements
- R1: After reset the block is in internal mode. `sstrb` is 1 with `sstrb_oe` 1, `dout_oe` is 0 and `track` is 0. `dout` shifts out zeros until a conversion has completed.
- R2: With `cs_n` low and no byte in progress, 0 bits on `din` (sampled at the rising `sclk` edge) are ignored. The first 1 becomes bit 7 of the control byte, and the next seven bits complete it.
- R3: Control byte fields are: bit 7 start, bits 6:4 channel select, bit 3 unipolar (1) or bipolar (0), bit 2 single-ended (1) or differential (0), bits 1:0 mode. Mode 11 is external, mode 10 is internal. When a conversion starts, `ch_sel`, `uni_mode` and `sgl_mode` take bits 6:4, 3 and 2. Modes 00 and 01 start nothing and leave the mode, the strobe and the channel outputs unchanged.
- R4: `track` rises on the falling `sclk` edge after the fifth control bit. It falls on the falling edge after the eighth bit, which is where hold and conversion begin.
- R5: In external mode `sstrb` is 1 for exactly one `sclk` period, from the falling edge after bit 0 of the control byte. The next twelve falling edges put the result on `dout` MSB first. `dout` is 0 after the LSB.
- R6: The SAR sets each trial bit from MSB to LSB on `dac_trial` and keeps it when `cmp_in` is 1. With a comparator that reads 1 for trial values at or below an input level, the result equals that level, including all-zeros and all-ones.
- R7: A 1 on `din` is not taken as a start bit until result bit 5 has been shifted out. From then on a new control byte is accepted, so external conversions can run back to back every 15 serial clocks.
- R8: In internal mode `sstrb` goes 0 at the falling edge after bit 0 of the control byte. It goes 1 after twelve tick-paced decisions. The result is held for any time, and the next falling `sclk` edges present it MSB first, then zeros.
- R9: With `cs_n` high, `dout_oe` is 0 and `din`/`sclk` are ignored, and a partially received control byte is dropped. `sstrb_oe` is 0 in external mode but stays 1 in internal mode, and an internal conversion already running completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sclk | input | 1 | Serial clock (asynchronous) |
| din | input | 1 | Serial data in |
| conv_tick | input | 1 | Internal conversion clock stand-in; each rising edge paces one decision |
| cmp_in | input | 1 | Comparator decision for the current trial word |
| dac_trial | output | RES_W | Trial word driven to the DAC |
| track | output | 1 | Acquisition window active |
| ch_sel | output | 3 | Channel select of the running conversion |
| uni_mode | output | 1 | 1 = unipolar coding |
| sgl_mode | output | 1 | 1 = single-ended input |
| dout | output | 1 | Serial data out value |
| dout_oe | output | 1 | Drive enable for `dout` |
| sstrb | output | 1 | Strobe value |
| sstrb_oe | output | 1 | Drive enable for `sstrb` |

## Verification
The bench uses the default 12-bit result width, two synchroniser stages and a reopen point of five remaining bits. The 12-bit width gives the all-zeros and all-ones result codes and the 15-clock back-to-back frame in which a new byte overlaps the last five result bits. Two stages give a fixed three-cycle path from a serial edge to a registered output, so a serial half period of eight system clocks leaves room to sample settled values. A tick period of ten system clocks stretches an internal conversion over more than a hundred cycles. That is long enough to toggle chip select in the middle of a conversion.

// File: rtl/sac_pkg.sv
package sac_pkg;
  typedef struct packed {
    logic       start;
    logic [2:0] sel;
    logic       uni;
    logic       sgl;
    logic [1:0] pd;
  } ctl_t;

  typedef enum logic [1:0] {PH_IDLE, PH_STROBE, PH_EXT, PH_INT} phase_t;
endpackage

// File: rtl/sac_sync.sv
module sac_sync #(
  parameter int         W       = 4,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[i] <= RST_VAL;
        else     st[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[i] <= RST_VAL;
        else     st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sac_ctl_rx.sv
module sac_ctl_rx
  import sac_pkg::*;
#(
  parameter int CTL_W = $bits(ctl_t),
  localparam int CNT_W = $clog2(CTL_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bit_en,
  input  logic             din,
  input  logic             listen,
  output logic             active,
  output logic [CNT_W-1:0] cnt,
  output logic             valid,
  output ctl_t             ctl_o
);
  logic [CTL_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active <= 1'b0;
      cnt    <= '0;
      valid  <= 1'b0;
      sh     <= '0;
    end else begin
      valid <= 1'b0;
      if (bit_en) begin
        if (!active) begin
          if (listen && din) begin
            active <= 1'b1;
            cnt    <= CNT_W'(1);
            sh     <= {sh[CTL_W-2:0], 1'b1};
          end
        end else begin
          sh <= {sh[CTL_W-2:0], din};
          if (cnt == CNT_W'(CTL_W - 1)) begin
            active <= 1'b0;
            valid  <= 1'b1;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  assign ctl_o = ctl_t'(sh);

  // R2
  start_bit_lead_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> ctl_o.start);
endmodule

// File: rtl/sac_sar.sv
module sac_sar #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         step,
  input  logic         cmp,
  output logic [W-1:0] trial,
  output logic [W-1:0] result,
  output logic         busy
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] res;
  logic [W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      res  <= '0;
      mask <= '0;
    end else if (start) begin
      res  <= '0;
      mask <= MSB_ONLY;
    end else if (step && (mask != '0)) begin
      if (cmp) res <= res | mask;
      mask <= mask >> 1;
    end
  end

  assign trial  = res | mask;
  assign result = res;
  assign busy   = (mask != '0);

  // R6
  trial_bit_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask));

  // R6
  kept_bits_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !start) |=> ((res & $past(res)) == $past(res)));
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sac_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int REOPEN      = 5,
  parameter int ACQ_BITS    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic             conv_tick,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_trial,
  output logic             track,
  output logic [2:0]       ch_sel,
  output logic             uni_mode,
  output logic             sgl_mode,
  output logic             dout,
  output logic             dout_oe,
  output logic             sstrb,
  output logic             sstrb_oe
);
  localparam int CTL_W    = $bits(ctl_t);
  localparam int CNT_W    = $clog2(CTL_W + 1);
  localparam int REM_W    = $clog2(RES_W + 1);
  localparam int TRACK_AT = CTL_W - ACQ_BITS;

  // synchronised inputs: {tick, din, cs_n, sclk}
  logic [3:0] sq;
  logic [1:0] prev;
  sac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
    .clk(clk), .rst(rst), .d({conv_tick, din, cs_n, sclk}), .q(sq)
  );

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= {sq[3], sq[0]};
  end

  logic cs_s, sclk_r, sclk_f, tick_r;
  assign cs_s   = sq[1];
  assign sclk_r = sq[0] & ~prev[0] & ~cs_s;
  assign sclk_f = ~sq[0] & prev[0] & ~cs_s;
  assign tick_r = sq[3] & ~prev[1];

  phase_t           phase;
  logic [REM_W-1:0] rem;
  logic [RES_W-1:0] out_sr;
  logic             ext_mode;
  logic             pend;
  ctl_t             pend_ctl;

  logic             listen;
  logic             rx_active, rx_valid;
  logic [CNT_W-1:0] rx_cnt;
  ctl_t             rx_ctl;

  assign listen = ((phase == PH_IDLE) || (phase == PH_EXT)) &&
                  (rem <= REM_W'(REOPEN)) && !pend;

  sac_ctl_rx #(.CTL_W(CTL_W)) u_rx (
    .clk(clk), .rst(rst), .clr(cs_s), .bit_en(sclk_r), .din(sq[2]),
    .listen(listen), .active(rx_active), .cnt(rx_cnt), .valid(rx_valid),
    .ctl_o(rx_ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      pend_ctl <= '0;
    end else if (rx_valid) begin
      pend     <= 1'b1;
      pend_ctl <= rx_ctl;
    end else if (sclk_f || cs_s) begin
      pend <= 1'b0;
    end
  end

  logic             sar_start, sar_step, sar_busy, int_done, ext_phase;
  logic [RES_W-1:0] sar_res;

  assign ext_phase = (phase == PH_STROBE) || (phase == PH_EXT);
  assign int_done  = (phase == PH_INT) && !sar_busy;
  assign sar_start = sclk_f && pend && pend_ctl.start && pend_ctl.pd[1] && !int_done;
  assign sar_step  = (ext_phase && sclk_f) || ((phase == PH_INT) && tick_r);

  sac_sar #(.W(RES_W)) u_sar (
    .clk(clk), .rst(rst), .start(sar_start), .step(sar_step), .cmp(cmp_in),
    .trial(dac_trial), .result(sar_res), .busy(sar_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      rem      <= '0;
      out_sr   <= '0;
      ext_mode <= 1'b0;
      dout     <= 1'b0;
      dout_oe  <= 1'b0;
      sstrb    <= 1'b1;
      sstrb_oe <= 1'b1;
      track    <= 1'b0;
      ch_sel   <= '0;
      uni_mode <= 1'b0;
      sgl_mode <= 1'b0;
    end else begin
      dout_oe  <= ~cs_s;
      sstrb_oe <= ~ext_mode | ~cs_s;
      if (cs_s)        track <= 1'b0;
      else if (sclk_f) track <= rx_active && (rx_cnt >= CNT_W'(TRACK_AT));

      if (int_done) begin
        phase  <= PH_IDLE;
        out_sr <= sar_res;
        rem    <= REM_W'(RES_W);
        sstrb  <= 1'b1;
      end else if (sar_start) begin
        dout     <= 1'b0;
        out_sr   <= '0;
        ch_sel   <= pend_ctl.sel;
        uni_mode <= pend_ctl.uni;
        sgl_mode <= pend_ctl.sgl;
        ext_mode <= pend_ctl.pd[0];
        if (pend_ctl.pd[0]) begin
          phase <= PH_STROBE;
          rem   <= REM_W'(RES_W);
          sstrb <= 1'b1;
        end else begin
          phase <= PH_INT;
          rem   <= '0;
          sstrb <= 1'b0;
        end
      end else if (sclk_f) begin
        if (ext_phase) begin
          sstrb <= 1'b0;
          dout  <= cmp_in;
          rem   <= rem - 1'b1;
          phase <= (rem == REM_W'(1)) ? PH_IDLE : PH_EXT;
        end else begin
          dout   <= out_sr[RES_W-1];
          out_sr <= {out_sr[RES_W-2:0], 1'b0};
          if (rem != '0) rem <= rem - 1'b1;
        end
      end
    end
  end

  // R9
  dout_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !dout_oe);

  // R9
  strobe_int_driven_chk: assert property (@(posedge clk) disable iff (rst)
    !ext_mode |=> sstrb_oe);

  // R5
  strobe_low_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXT) |-> !sstrb);

  // R8
  strobe_low_int_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_INT) |-> !sstrb);

  // R7
  start_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_active) |-> ($past(rem) <= REM_W'(REOPEN)));

  // R4
  hold_ends_track_chk: assert property (@(posedge clk) disable iff (rst)
    sar_start |=> !track);
endmodule

// File: tb/tb_sar_serial_seq.sv
module tb_sar_serial_seq;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst, cs_n, sclk, din, conv_tick, cmp_in;
  logic [11:0] dac_trial;
  logic track, uni_mode, sgl_mode, dout, dout_oe, sstrb, sstrb_oe;
  logic [2:0] ch_sel;
  logic [11:0] tgt;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sar_serial_seq dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .conv_tick(conv_tick), .cmp_in(cmp_in), .dac_trial(dac_trial),
    .track(track), .ch_sel(ch_sel), .uni_mode(uni_mode), .sgl_mode(sgl_mode),
    .dout(dout), .dout_oe(dout_oe), .sstrb(sstrb), .sstrb_oe(sstrb_oe)
  );

  // comparator model: reads 1 while the trial word is at or below the level (R6)
  assign cmp_in = (dac_trial <= tgt);

  initial begin
    conv_tick = 1'b0;
    forever begin
      repeat (5) @(negedge clk);
      conv_tick = ~conv_tick;
    end
  end

  // behavioural reference model
  bit         m_ext = 0, m_act = 0, m_pend = 0, m_strb_on = 0, m_ibusy = 0;
  bit         m_sstrb = 1, m_track = 0, m_uni = 0, m_sgl = 0;
  int         m_cnt = 0;
  logic [7:0] m_byte = '0;
  logic [2:0] m_sel = '0;
  bit         m_q[$];

  task automatic chk(input string tg, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tg, act, exp);
    end
  endtask

  task automatic load_q();
    m_q.delete();
    for (int i = 11; i >= 0; i--) m_q.push_back(tgt[i]);
  endtask

  task automatic sck_raw(input bit b);
    din = b;
    repeat (HP) @(negedge clk);
    sclk = 1'b1;
    repeat (HP) @(negedge clk);
    sclk = 1'b0;
    repeat (HP - 2) @(negedge clk);
  endtask

  task automatic sck(input bit b, input string tg);
    bit lis, e_dout;
    sck_raw(b);
    lis = (m_q.size() <= 5) && !m_strb_on && !m_ibusy && !m_pend;
    if (!m_act) begin
      if (lis && b) begin
        m_act = 1; m_cnt = 1; m_byte = {m_byte[6:0], 1'b1};
      end
    end else begin
      m_byte = {m_byte[6:0], b};
      m_cnt++;
      if (m_cnt == 8) begin m_act = 0; m_pend = 1; end
    end
    e_dout = 0;
    if (m_pend && m_byte[1]) begin
      m_pend = 0;
      m_sel = m_byte[6:4]; m_uni = m_byte[3]; m_sgl = m_byte[2];
      m_ext = m_byte[0];
      if (m_ext) begin m_sstrb = 1; m_strb_on = 1; load_q(); end
      else begin m_sstrb = 0; m_ibusy = 1; m_q.delete(); end
    end else begin
      m_pend = 0;
      if (m_strb_on) begin m_strb_on = 0; m_sstrb = 0; end
      if (m_q.size() > 0) e_dout = m_q.pop_front();
    end
    m_track = m_act && (m_cnt >= 5);
    chk({tg, " dout"}, dout, e_dout);
    chk({tg, " sstrb"}, sstrb, m_sstrb);
    chk("R4 track", track, m_track);
    chk("R9 dout_oe", dout_oe, 1);
    chk("R9 sstrb_oe", sstrb_oe, 1);
    chk("R3 ch_sel", ch_sel, m_sel);
    chk("R3 uni_mode", uni_mode, m_uni);
    chk("R3 sgl_mode", sgl_mode, m_sgl);
  endtask

  task automatic send_byte(input logic [7:0] v, input string tg);
    for (int i = 7; i >= 0; i--) sck(v[i], tg);
  endtask

  task automatic bits(input bit b, input int n, input string tg);
    for (int i = 0; i < n; i++) sck(b, tg);
  endtask

  task automatic wait_int(input string tg);
    int n;
    n = 0;
    while (sstrb !== 1'b1 && n < 600) begin
      @(negedge clk);
      n++;
    end
    chk({tg, " conversion length >= 12 ticks"}, (n >= 90), 1);
    chk({tg, " sstrb done"}, sstrb, 1);
    m_ibusy = 0; m_sstrb = 1; load_q();
  endtask

  task automatic cs_high(input string tg);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    m_act = 0; m_cnt = 0; m_pend = 0;
    chk({tg, " dout_oe off"}, dout_oe, 0);
    chk({tg, " sstrb_oe"}, sstrb_oe, m_ext ? 0 : 1);
  endtask

  task automatic cs_low(input string tg);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    chk({tg, " dout_oe on"}, dout_oe, 1);
    chk({tg, " sstrb_oe"}, sstrb_oe, 1);
    chk({tg, " sstrb"}, sstrb, m_sstrb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; tgt = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dout_oe", dout_oe, 0);
    chk("R1 sstrb", sstrb, 1);
    chk("R1 sstrb_oe", sstrb_oe, 1);
    chk("R1 track", track, 0);
    cs_low("R1");
    bits(0, 4, "R1");

    // R2 leading zeros, then R5 external conversion
    bits(0, 3, "R2");
    tgt = 12'hA5C;
    send_byte(8'hDF, "R5");
    bits(0, 14, "R5");

    // R6 extreme codes
    tgt = 12'hFFF;
    send_byte(8'h8F, "R6");
    bits(0, 13, "R6");
    tgt = 12'h000;
    send_byte(8'hBF, "R6");
    bits(0, 13, "R6");

    // R7 early ones ignored, then back-to-back frame of 15 clocks
    tgt = 12'h5A3;
    send_byte(8'hCF, "R7");
    bits(1, 7, "R7");
    send_byte(8'hEB, "R7");
    bits(0, 14, "R7");

    // R3 power-down code starts nothing
    send_byte(8'h9C, "R3");
    bits(0, 4, "R3");

    // R8 internal conversion, result held
    tgt = 12'h3C1;
    send_byte(8'hA2, "R8");
    wait_int("R8");
    repeat (200) @(negedge clk);
    bits(0, 14, "R8");

    // R9 data ignored while deselected
    cs_high("R9");
    for (int i = 0; i < 10; i++) sck_raw(1'b1);
    cs_low("R9");
    bits(0, 3, "R9");

    // R9 internal conversion continues with chip select high
    tgt = 12'h7E4;
    send_byte(8'hF6, "R9");
    cs_high("R9");
    wait_int("R9");
    cs_low("R9");
    bits(0, 13, "R9");

    // R9 external strobe released while deselected, conversion resumes
    tgt = 12'h123;
    send_byte(8'h8F, "R9");
    bits(0, 4, "R9");
    cs_high("R9");
    cs_low("R9");
    bits(0, 10, "R9");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule